// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block sits beside a processor core and decides, for each interrupt request, whether it may interrupt the work in progress. Each of the request lines has a fixed rank, and the controller tracks the rank of the interrupt now being served. A request that outranks that service is taken at the next instruction boundary. A request that does not outrank it is held off until enough returns have lowered the service rank.

Taking an interrupt is a fixed sequence. The controller waits for the core to report an instruction boundary and captures the core's program counter and status word at that point. It pushes them onto an on-chip context stack together with the current service rank. Next it acknowledges the winning line. Last it tells the core to load the handler address for that line, which it computes from a vector base and stride.

A return strobe from the core pops the most recent context. The controller then hands back the saved program counter and status word and restores the saved service rank. Nested handlers therefore unwind in the reverse order of entry.

Top module: `irq_nest_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `serv_level` is 0 and `irq_ack`, `pc_load`, `psw_load` and `overflow_err` are all low.
- R2: When several lines request at once, the highest-numbered line wins. Line NUM_LINES-1 has the top rank and line 0 the lowest.
- R3: The service rank of line i is i+1, and the idle state has rank 0. A request is taken only if its rank is strictly greater than `serv_level`. A request of equal or lower rank gets no acknowledge and waits.
- R4: No acknowledge is given until `insn_done` has been sampled high after the request became eligible. The acknowledge comes two clock edges after the edge that sampled `insn_done`.
- R5: Entry produces a one-cycle `irq_ack` pulse with `ack_line` set to the winning line. In the next cycle it produces a one-cycle `pc_load` pulse with `psw_load` low and `new_pc` = VEC_BASE + line*VEC_STRIDE. In that same cycle `serv_level` becomes line+1.
- R6: Entry pushes the `cur_pc`, `cur_psw` and `serv_level` values present when `insn_done` was sampled. A `rti` pulse pops the most recent entry. Two edges later, one cycle carries `pc_load` and `psw_load` together with the saved PC on `new_pc`, the saved status on `restored_psw`, and the saved rank on `serv_level`. Contexts are restored last-in, first-out.
- R7: A `rti` pulse while `serv_level` is 0 (stack empty) is ignored. No load strobe appears and `serv_level` stays 0.
- R8: An entry attempted while the stack already holds STACK_DEPTH contexts sets `overflow_err`, which then stays set until reset. That entry gives no acknowledge and no load, and `serv_level` is unchanged. With the default depth of NUM_LINES, a full nesting of every line does not set it.
- R9: When `rti` and an eligible request arrive in the same cycle, the return is performed first. The request is then re-judged against the restored rank and taken only at a later instruction boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_LINES | Level-sensitive request lines, bit i is line i |
| insn_done | input | 1 | Strobe: the core has completed an instruction |
| cur_pc | input | PC_W | Core program counter at the boundary |
| cur_psw | input | PSW_W | Core status word at the boundary |
| rti | input | 1 | Strobe: return from the current handler |
| irq_ack | output | 1 | One-cycle acknowledge of the taken line |
| ack_line | output | $clog2(NUM_LINES) | Index of the acknowledged line |
| pc_load | output | 1 | One-cycle strobe: core loads `new_pc` |
| new_pc | output | PC_W | Handler address on entry, saved PC on return |
| psw_load | output | 1 | One-cycle strobe: core loads `restored_psw` |
| restored_psw | output | PSW_W | Saved status word on return |
| serv_level | output | $clog2(NUM_LINES)+1 | Rank of the interrupt being served, 0 when idle |
| overflow_err | output | 1 | Sticky flag: entry refused because the stack was full |

## Verification
The overflow path is the hardest to reach. Every entry must strictly raise the service rank, so with the default depth the stack can never be filled past its limit from the ports. The bench therefore adds a second instance built with a two-deep stack and nests three rising lines into it. A second awkward case is a return strobe that lands in the same cycle as a new eligible request. The bench drives both in one cycle, checks that the return comes out first, and only then supplies the boundary that admits the request. Full eight-level nesting followed by eight returns checks the last-in, first-out order of the restored contexts.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_WAITB   = 3'd1,
    ST_PUSH    = 3'd2,
    ST_LOAD    = 3'd3,
    ST_RESTORE = 3'd4
  } nest_state_t;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_LINES = 8,
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int LVL_W  = LINE_W + 1
) (
  input  logic [NUM_LINES-1:0] req,
  output logic                 win_valid,
  output logic [LINE_W-1:0]    win_line,
  output logic [LVL_W-1:0]     win_level
);
  // later iterations overwrite earlier ones, so the top set bit wins
  always_comb begin
    win_valid = 1'b0;
    win_line  = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (req[i]) begin
        win_valid = 1'b1;
        win_line  = LINE_W'(i);
      end
    end
    win_level = win_valid ? (LVL_W'(win_line) + LVL_W'(1)) : '0;
  end
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
  parameter int          NUM_LINES = 8,
  parameter int          PC_W      = 16,
  parameter int unsigned VEC_BASE  = 32'h1000,
  parameter int unsigned VEC_STRIDE = 32'h40,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic [LINE_W-1:0] line,
  output logic [PC_W-1:0]   handler_pc
);
  logic [PC_W-1:0] tbl [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_entry
    assign tbl[g] = PC_W'(VEC_BASE + VEC_STRIDE * g);
  end

  assign handler_pc = tbl[line];
endmodule

// File: rtl/irq_ctx_stack.sv
module irq_ctx_stack #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 28,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  // plain dual-port array with registered read: maps onto block RAM
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int          NUM_LINES   = 8,
  parameter int          PC_W        = 16,
  parameter int          PSW_W       = 8,
  parameter int          STACK_DEPTH = NUM_LINES,
  parameter int unsigned VEC_BASE    = 32'h1000,
  parameter int unsigned VEC_STRIDE  = 32'h40
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_LINES-1:0]          irq_req,
  input  logic                          insn_done,
  input  logic [PC_W-1:0]               cur_pc,
  input  logic [PSW_W-1:0]              cur_psw,
  input  logic                          rti,
  output logic                          irq_ack,
  output logic [$clog2(NUM_LINES)-1:0]  ack_line,
  output logic                          pc_load,
  output logic [PC_W-1:0]               new_pc,
  output logic                          psw_load,
  output logic [PSW_W-1:0]              restored_psw,
  output logic [$clog2(NUM_LINES):0]    serv_level,
  output logic                          overflow_err
);
  import irq_nest_pkg::*;

  localparam int LINE_W = $clog2(NUM_LINES);
  localparam int LVL_W  = LINE_W + 1;
  localparam int FR_W   = PC_W + PSW_W + LVL_W;
  localparam int ADDR_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam int SP_W   = $clog2(STACK_DEPTH + 1);

  nest_state_t       st;
  logic [SP_W-1:0]   sp;
  logic [SP_W-1:0]   sp_dec;
  logic [LVL_W-1:0]  level_q;
  logic [LINE_W-1:0] sel_line;
  logic [PC_W-1:0]   ctx_pc;
  logic [PSW_W-1:0]  ctx_psw;

  logic              win_valid;
  logic [LINE_W-1:0] win_line;
  logic [LVL_W-1:0]  win_level;
  logic              preempt;
  logic              stack_full;
  logic              pop_now;

  logic              st_we, st_re;
  logic [FR_W-1:0]   st_wdata, st_rdata;
  logic [PC_W-1:0]   vec_pc;

  irq_prio_pick #(.NUM_LINES(NUM_LINES)) u_pick (
    .req       (irq_req),
    .win_valid (win_valid),
    .win_line  (win_line),
    .win_level (win_level)
  );

  irq_vec_table #(
    .NUM_LINES (NUM_LINES),
    .PC_W      (PC_W),
    .VEC_BASE  (VEC_BASE),
    .VEC_STRIDE(VEC_STRIDE)
  ) u_vec (
    .line      (sel_line),
    .handler_pc(vec_pc)
  );

  irq_ctx_stack #(.DEPTH(STACK_DEPTH), .WIDTH(FR_W)) u_stack (
    .clk   (clk),
    .we    (st_we),
    .waddr (sp[ADDR_W-1:0]),
    .wdata (st_wdata),
    .re    (st_re),
    .raddr (sp_dec[ADDR_W-1:0]),
    .rdata (st_rdata)
  );

  always_comb begin
    preempt    = win_valid && (win_level > level_q);
    stack_full = (sp == SP_W'(STACK_DEPTH));
    sp_dec     = sp - SP_W'(1);
    pop_now    = rti && (sp != '0) && ((st == ST_RUN) || (st == ST_WAITB));
    st_we      = (st == ST_PUSH) && !stack_full;
    st_re      = pop_now;
    st_wdata   = {ctx_pc, ctx_psw, level_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_RUN;
      sp           <= '0;
      level_q      <= '0;
      sel_line     <= '0;
      ctx_pc       <= '0;
      ctx_psw      <= '0;
      irq_ack      <= 1'b0;
      ack_line     <= '0;
      pc_load      <= 1'b0;
      psw_load     <= 1'b0;
      new_pc       <= '0;
      restored_psw <= '0;
      overflow_err <= 1'b0;
    end else begin
      irq_ack  <= 1'b0;
      pc_load  <= 1'b0;
      psw_load <= 1'b0;
      case (st)
        ST_RUN, ST_WAITB: begin
          if (pop_now) begin
            sp <= sp_dec;
            st <= ST_RESTORE;
          end else if (st == ST_RUN) begin
            if (preempt) st <= ST_WAITB;
          end else if (insn_done) begin
            if (preempt) begin
              sel_line <= win_line;
              ctx_pc   <= cur_pc;
              ctx_psw  <= cur_psw;
              st       <= ST_PUSH;
            end else begin
              st <= ST_RUN;
            end
          end else if (!preempt) begin
            st <= ST_RUN;
          end
        end
        ST_PUSH: begin
          if (stack_full) begin
            overflow_err <= 1'b1;
            st           <= ST_RUN;
          end else begin
            sp       <= sp + SP_W'(1);
            irq_ack  <= 1'b1;
            ack_line <= sel_line;
            st       <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          pc_load <= 1'b1;
          new_pc  <= vec_pc;
          level_q <= LVL_W'(sel_line) + LVL_W'(1);
          st      <= ST_RUN;
        end
        ST_RESTORE: begin
          pc_load      <= 1'b1;
          psw_load     <= 1'b1;
          new_pc       <= st_rdata[FR_W-1 -: PC_W];
          restored_psw <= st_rdata[LVL_W+PSW_W-1 -: PSW_W];
          level_q      <= st_rdata[LVL_W-1:0];
          st           <= ST_RUN;
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign serv_level = level_q;
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
  parameter int LINE_W = 3,
  parameter int LVL_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              insn_done,
  input logic              irq_ack,
  input logic [LINE_W-1:0] ack_line,
  input logic              pc_load,
  input logic              psw_load,
  input logic [LVL_W-1:0]  serv_level,
  input logic              overflow_err
);
  assert_ack_outranks_R3: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> ((LVL_W'(ack_line) + LVL_W'(1)) > serv_level));

  assert_ack_after_boundary_R4: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> $past(insn_done, 2));

  assert_ack_single_R5: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack);

  assert_ack_then_load_R5: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> (pc_load && !psw_load));

  assert_entry_level_R5: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> (serv_level == (LVL_W'($past(ack_line)) + LVL_W'(1))));

  assert_psw_with_pc_R6: assert property (@(posedge clk) disable iff (rst)
    psw_load |-> pc_load);

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overflow_err |=> overflow_err);
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(.LINE_W(LINE_W), .LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .insn_done   (insn_done),
  .irq_ack     (irq_ack),
  .ack_line    (ack_line),
  .pc_load     (pc_load),
  .psw_load    (psw_load),
  .serv_level  (serv_level),
  .overflow_err(overflow_err)
);

// File: tb/test_irq_nest_ctrl.sv
`timescale 1ns/1ps
module test_irq_nest_ctrl;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  // main instance
  logic [N-1:0] irq = '0;
  logic         bnd = 1'b0, ret = 1'b0;
  logic [15:0]  pc = '0;
  logic [7:0]   psw = '0;
  logic         ack, pcl, pswl, err;
  logic [2:0]   aline;
  logic [15:0]  npc;
  logic [7:0]   rpsw;
  logic [3:0]   lvl;

  irq_nest_ctrl i_irq_nest_ctrl (
    .clk(clk), .rst(rst), .irq_req(irq), .insn_done(bnd), .cur_pc(pc),
    .cur_psw(psw), .rti(ret), .irq_ack(ack), .ack_line(aline),
    .pc_load(pcl), .new_pc(npc), .psw_load(pswl), .restored_psw(rpsw),
    .serv_level(lvl), .overflow_err(err));

  // shallow instance for the overflow case
  logic [N-1:0] s_irq = '0;
  logic         s_bnd = 1'b0;
  logic         s_ack, s_pcl, s_pswl, s_err;
  logic [2:0]   s_aline;
  logic [15:0]  s_npc;
  logic [7:0]   s_rpsw;
  logic [3:0]   s_lvl;
  int           s_ack_n = 0;

  irq_nest_ctrl #(.STACK_DEPTH(2)) i_irq_nest_ctrl_shallow (
    .clk(clk), .rst(rst), .irq_req(s_irq), .insn_done(s_bnd), .cur_pc(16'h0),
    .cur_psw(8'h0), .rti(1'b0), .irq_ack(s_ack), .ack_line(s_aline),
    .pc_load(s_pcl), .new_pc(s_npc), .psw_load(s_pswl), .restored_psw(s_rpsw),
    .serv_level(s_lvl), .overflow_err(s_err));

  always @(negedge clk) if (!rst && s_ack) s_ack_n++;

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard: kind 1 = ack(line in pc field), 2 = entry load, 3 = return load
  typedef struct packed { logic [1:0] kind; logic [7:0] psw; logic [15:0] pc; } ev_t;
  ev_t   exp_q[$];
  string tag_q[$];

  task automatic expect_ev(input logic [1:0] k, input logic [7:0] s, input logic [15:0] p, input string tag);
    exp_q.push_back('{kind: k, psw: s, pc: p});
    tag_q.push_back(tag);
  endtask

  task automatic compare(input ev_t got);
    if (exp_q.size() == 0) begin
      chk(1'b0, "unexpected output event", 32'(got), 32'h0);
    end else begin
      ev_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(got == e, t, 32'(got), 32'(e));
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (ack) compare('{kind: 2'd1, psw: 8'h0, pc: 16'(aline)});
      if (pcl) begin
        if (pswl) compare('{kind: 2'd3, psw: rpsw, pc: npc});
        else      compare('{kind: 2'd2, psw: 8'h0, pc: npc});
      end
      if (pswl && !pcl) chk(1'b0, "R6 status load without pc load", 32'd1, 32'd0);
    end
  end

  function automatic logic [15:0] vec(input int l);
    return 16'h1000 + 16'(l) * 16'h40;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_bnd();
    bnd = 1'b1; cyc(1); bnd = 1'b0;
  endtask

  task automatic pulse_ret();
    ret = 1'b1; cyc(1); ret = 1'b0;
  endtask

  task automatic drained(input string tag);
    chk(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'd0);
  endtask

  task automatic enter(input int l, input logic [15:0] p, input logic [7:0] s, input string tag);
    pc = p; psw = s; irq[l] = 1'b1;
    cyc(2);
    expect_ev(2'd1, 8'h0, 16'(l), {tag, " ack line"});
    expect_ev(2'd2, 8'h0, vec(l), {tag, " handler pc"});
    pulse_bnd();
    cyc(5);
    irq[l] = 1'b0;
    drained({tag, " entry events"});
    chk(lvl == 4'(l + 1), {tag, " level after entry"}, 32'(lvl), 32'(l + 1));
  endtask

  task automatic leave(input logic [15:0] p, input logic [7:0] s, input int exp_lvl, input string tag);
    expect_ev(2'd3, s, p, {tag, " restored context"});
    pulse_ret();
    cyc(4);
    drained({tag, " return events"});
    chk(lvl == 4'(exp_lvl), {tag, " level after return"}, 32'(lvl), 32'(exp_lvl));
  endtask

  task automatic s_enter(input int l);
    s_irq[l] = 1'b1; cyc(2);
    s_bnd = 1'b1; cyc(1); s_bnd = 1'b0;
    cyc(5); s_irq[l] = 1'b0; cyc(1);
  endtask

  initial begin
    cyc(3);
    // R1: reset state
    chk(lvl == 0 && !ack && !pcl && !pswl && !err, "R1 outputs in reset",
        {lvl, 1'b0, ack, pcl, pswl, err}, 32'h0);
    rst = 1'b0;
    cyc(1);
    chk(lvl == 0 && !err, "R1 outputs after reset", {lvl, err}, 32'h0);

    // R4: request held without a boundary is not taken
    pc = 16'h0100; psw = 8'h11; irq[2] = 1'b1;
    cyc(6);
    chk(lvl == 0, "R4 no entry before boundary", 32'(lvl), 32'd0);
    irq[2] = 1'b0;
    cyc(1);
    enter(2, 16'h0100, 8'h11, "R5 line 2");

    // R3: lower rank waits
    pc = 16'h0200; psw = 8'h22; irq[1] = 1'b1;
    cyc(2); pulse_bnd(); cyc(5);
    chk(lvl == 4'd3, "R3 lower rank not taken", 32'(lvl), 32'd3);
    // R3: equal rank waits
    irq[2] = 1'b1;
    cyc(2); pulse_bnd(); cyc(5);
    chk(lvl == 4'd3, "R3 equal rank not taken", 32'(lvl), 32'd3);
    irq[2] = 1'b0;

    // R2: simultaneous requests 5 and 1, line 5 wins; R3 strictly higher preempts
    enter(5, 16'h0200, 8'h22, "R2 R3 line 5 over line 1");

    // R6: unwind, line 1 still held and waiting
    leave(16'h0200, 8'h22, 3, "R6 pop 1");
    leave(16'h0100, 8'h11, 0, "R6 pop 2");
    // line 1 now outranks idle and is taken at the next boundary
    expect_ev(2'd1, 8'h0, 16'd1, "R3 waiting line 1 ack");
    expect_ev(2'd2, 8'h0, vec(1), "R3 waiting line 1 pc");
    pc = 16'h0300; psw = 8'h33;
    pulse_bnd(); cyc(5);
    irq[1] = 1'b0;
    drained("R3 waiting line entry");
    chk(lvl == 4'd2, "R3 waiting line level", 32'(lvl), 32'd2);
    leave(16'h0300, 8'h33, 0, "R6 pop 3");

    // R7: return with nothing served
    pulse_ret(); cyc(4);
    chk(lvl == 0, "R7 idle return ignored", 32'(lvl), 32'd0);
    drained("R7 no events");

    // R9: return and new request in the same cycle
    enter(3, 16'h0400, 8'h44, "R9 setup line 3");
    expect_ev(2'd3, 8'h44, 16'h0400, "R9 return first");
    irq[6] = 1'b1; ret = 1'b1;
    cyc(1); ret = 1'b0;
    cyc(4);
    drained("R9 return done");
    chk(lvl == 0, "R9 level restored before entry", 32'(lvl), 32'd0);
    expect_ev(2'd1, 8'h0, 16'd6, "R9 later ack");
    expect_ev(2'd2, 8'h0, vec(6), "R9 later pc");
    pc = 16'h0500; psw = 8'h55;
    pulse_bnd(); cyc(5);
    irq[6] = 1'b0;
    drained("R9 entry done");
    chk(lvl == 4'd7, "R9 level after entry", 32'(lvl), 32'd7);
    leave(16'h0500, 8'h55, 0, "R9 unwind");

    // R6 and R8: full nesting of every line, then LIFO unwind
    for (int i = 0; i < N; i++) enter(i, 16'h0600 + 16'(i), 8'(i), "R6 nest");
    chk(lvl == 4'd8 && !err, "R8 full nesting without overflow", {lvl, err}, 32'h10);
    for (int i = N - 1; i >= 0; i--) leave(16'h0600 + 16'(i), 8'(i), i == 0 ? 0 : i, "R6 LIFO");

    // R8: overflow on the two-deep instance
    s_enter(0);
    s_enter(1);
    chk(s_lvl == 4'd2 && !s_err, "R8 shallow two entries", {s_lvl, s_err}, 32'h4);
    s_enter(2);
    chk(s_err == 1'b1, "R8 overflow flag", 32'(s_err), 32'd1);
    chk(s_lvl == 4'd2, "R8 level unchanged on overflow", 32'(s_lvl), 32'd2);
    chk(s_ack_n == 2, "R8 no ack on overflow", 32'(s_ack_n), 32'd2);
    cyc(4);
    chk(s_err == 1'b1, "R8 overflow sticky", 32'(s_err), 32'd1);

    drained("final scoreboard empty");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule